// File: doc/BRIEF.md
# Twelve-Channel Load Switch Control Core

This block is the digital heart of a load switch with four high-side and eight low-side outputs. A host writes 16-bit serial frames: one kind sets the on/off state of all twelve outputs, a second kind enables per-channel direct control from dedicated input pins, and a third picks what each of the two current-sense outputs reports. The sense outputs can report the lower channel of their pair, the upper channel, or the sum of both. All pins are asynchronous to the core clock. They are brought into the clock domain through synchronizers. The serial clock is oversampled, so the serial clock must run well below the core clock.

A failsafe request forces high-side channels 0 and 2 on. That state persists until a reset arrives or a new accepted frame reinitializes the part. Normal serial-driven operation then resumes at once. The analog drivers, current limiting and protection sit outside this core. Here the core drives a registered enable per output and a 2-bit code per sense output.

Top module: `load_switch_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every output enable is 0, direct control is disabled (the low-side mask is 0) and both sense codes are 00.
- R2: A frame is 16 bits, sampled on rising serial clock edges while chip select is low, MSB first. A frame with bits 15:14 = 00 is an output frame: bit k (k = 0..3) sets high-side enable k, and bit 4+j (j = 0..7) sets low-side enable j.
- R3: In an output frame, bits 13:12 have no effect on any output.
- R4: A frame takes effect only at the rising edge of chip select, and only if exactly 16 rising serial clock edges occurred while chip select was low. Serial clock edges while chip select is high are not counted.
- R5: A frame with bits 15:14 = 01 is a direct-control frame. Bits 3:0 enable direct control of high-side channels 3..0. Bits 11:4 form the mask of low-side channels 7..0 that follow the low-side direct input.
- R6: A high-side channel with direct control enabled outputs its serial bit OR its direct input. With direct control disabled, its direct input has no effect.
- R7: Each low-side enable equals its serial bit OR (low-side direct input AND its mask bit). Channels outside the mask ignore the direct input.
- R8: A frame with bits 15:14 = 10 is a sense frame. Bits 1:0 set the sense code for pair 0/1 and bits 3:2 set it for pair 2/3. The codes are 00 = lower channel, 01 = upper channel and 10 = sum. A field of 11 leaves that code unchanged.
- R9: While the failsafe request is high, high-side enables 0 and 2 are forced on. After the request drops they stay forced until reset, or until an accepted frame of kind 00, 01 or 10 arrives while the request is low. That frame's content applies immediately.
- R10: A frame with bits 15:14 = 11 changes nothing, and it does not end failsafe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| hs_direct | input | 4 | Direct inputs for high-side channels 3..0 |
| ls_direct | input | 1 | Shared low-side direct input |
| fs_req | input | 1 | Failsafe request, active high |
| hs_en | output | 4 | High-side output enables |
| ls_en | output | 8 | Low-side output enables (bit 0 is the first low-side channel) |
| sns01_sel | output | 2 | Sense code for pair 0/1 |
| sns23_sel | output | 2 | Sense code for pair 2/3 |

## Verification
The bench sends frames of 15 and 17 bits, and toggles the serial clock while chip select is high. A design with a wrong bit count would either load a truncated frame or refuse a good one that follows. Output frames with bits 13:12 set catch a decoder that lets those bits spill into the low-side enables. Direct inputs are toggled with their enables on and off. A failsafe request is held across a frame and then released, so a core that clears failsafe too early or never clears it shows a wrong high-side 0 or 2. A sense field of 11 checks that the code is held rather than loaded.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int FRAME_W_DEF = 16;
  localparam int NUM_HS_DEF  = 4;
  localparam int NUM_LS_DEF  = 8;

  typedef enum logic [1:0] {
    FRM_OUT = 2'b00,
    FRM_DIR = 2'b01,
    FRM_SNS = 2'b10,
    FRM_RSV = 2'b11
  } frm_kind_e;

  typedef enum logic [1:0] {
    SNS_LO  = 2'b00,
    SNS_HI  = 2'b01,
    SNS_SUM = 2'b10,
    SNS_KEEP = 2'b11
  } sns_code_e;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lsw_spi_rx.sv
module lsw_spi_rx #(
  parameter int FRAME_W = lsw_pkg::FRAME_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               mosi_i,
  output logic               frm_vld_o,
  output logic [FRAME_W-1:0] frm_data_o
);
  localparam int               CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sclk_d_q, cs_d_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sclk_rise, cs_rise, sh_en;

  assign sclk_rise = sclk_i & ~sclk_d_q;
  assign cs_rise   = cs_n_i & ~cs_d_q;
  assign sh_en     = ~cs_n_i & sclk_rise;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (cs_n_i) begin
      cnt_d = '0;
    end else if (sh_en) begin
      sh_d = {sh_q[FRAME_W-2:0], mosi_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      sclk_d_q <= sclk_i;
      cs_d_q   <= cs_n_i;
      cnt_q    <= cnt_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign frm_vld_o  = cs_rise && (cnt_q == CNT_FULL);
  assign frm_data_o = sh_q;

  // R4
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && cs_d_q) |=> (cnt_q == '0));
endmodule

// File: rtl/lsw_cfg_regs.sv
module lsw_cfg_regs
  import lsw_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int NUM_HS  = NUM_HS_DEF,
  parameter int NUM_LS  = NUM_LS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_vld_i,
  input  logic [FRAME_W-1:0] frm_data_i,
  input  logic               fs_req_i,
  output logic [NUM_HS-1:0]  spi_hs_o,
  output logic [NUM_LS-1:0]  spi_ls_o,
  output logic [NUM_HS-1:0]  hs_den_o,
  output logic [NUM_LS-1:0]  ls_mask_o,
  output logic [1:0]         sns01_o,
  output logic [1:0]         sns23_o,
  output logic               fs_o
);
  localparam int LS_LSB   = NUM_HS;
  localparam int KIND_LSB = FRAME_W - 2;

  frm_kind_e         kind;
  logic              ld_out, ld_dir, ld_sns, ld_any;
  logic [NUM_HS-1:0] spi_hs_q, hs_den_q;
  logic [NUM_LS-1:0] spi_ls_q, ls_mask_q;
  logic [1:0]        sns01_q, sns01_d, sns23_q, sns23_d;
  logic              fs_q, fs_d;

  assign kind   = frm_kind_e'(frm_data_i[KIND_LSB +: 2]);
  assign ld_out = frm_vld_i && (kind == FRM_OUT);
  assign ld_dir = frm_vld_i && (kind == FRM_DIR);
  assign ld_sns = frm_vld_i && (kind == FRM_SNS);
  assign ld_any = ld_out | ld_dir | ld_sns;

  always_comb begin
    sns01_d = sns01_q;
    sns23_d = sns23_q;
    if (frm_data_i[1:0] != SNS_KEEP) sns01_d = frm_data_i[1:0];
    if (frm_data_i[3:2] != SNS_KEEP) sns23_d = frm_data_i[3:2];
    if (fs_req_i)    fs_d = 1'b1;
    else if (ld_any) fs_d = 1'b0;
    else             fs_d = fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_hs_q  <= '0;
      spi_ls_q  <= '0;
      hs_den_q  <= '0;
      ls_mask_q <= '0;
      sns01_q   <= SNS_LO;
      sns23_q   <= SNS_LO;
      fs_q      <= 1'b0;
    end else begin
      if (ld_out) begin
        spi_hs_q <= frm_data_i[0 +: NUM_HS];
        spi_ls_q <= frm_data_i[LS_LSB +: NUM_LS];
      end
      if (ld_dir) begin
        hs_den_q  <= frm_data_i[0 +: NUM_HS];
        ls_mask_q <= frm_data_i[LS_LSB +: NUM_LS];
      end
      if (ld_sns) begin
        sns01_q <= sns01_d;
        sns23_q <= sns23_d;
      end
      fs_q <= fs_d;
    end
  end

  assign spi_hs_o  = spi_hs_q;
  assign spi_ls_o  = spi_ls_q;
  assign hs_den_o  = hs_den_q;
  assign ls_mask_o = ls_mask_q;
  assign sns01_o   = sns01_q;
  assign sns23_o   = sns23_q;
  assign fs_o      = fs_q;

  // R2
  out_frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && frm_data_i[KIND_LSB +: 2] == 2'b00) |=>
      (spi_hs_q == $past(frm_data_i[0 +: NUM_HS]) &&
       spi_ls_q == $past(frm_data_i[LS_LSB +: NUM_LS])));
  // R4
  no_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld_i |=> ($stable(spi_hs_q) && $stable(spi_ls_q) && $stable(hs_den_q) &&
                    $stable(ls_mask_q) && $stable(sns01_q) && $stable(sns23_q)));
  // R8
  sense_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sns01_q != 2'b11) && (sns23_q != 2'b11));
  // R10
  rsv_frame_keeps_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && frm_vld_i && frm_data_i[KIND_LSB +: 2] == 2'b11) |=> fs_q);
endmodule

// File: rtl/lsw_out_stage.sv
module lsw_out_stage #(
  parameter int                NUM_HS   = lsw_pkg::NUM_HS_DEF,
  parameter int                NUM_LS   = lsw_pkg::NUM_LS_DEF,
  parameter logic [NUM_HS-1:0] FS_FORCE = NUM_HS'(4'b0101)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HS-1:0] spi_hs_i,
  input  logic [NUM_LS-1:0] spi_ls_i,
  input  logic [NUM_HS-1:0] hs_den_i,
  input  logic [NUM_LS-1:0] ls_mask_i,
  input  logic [NUM_HS-1:0] hs_dir_i,
  input  logic              ls_dir_i,
  input  logic              fs_i,
  output logic [NUM_HS-1:0] hs_en_o,
  output logic [NUM_LS-1:0] ls_en_o
);
  logic [NUM_HS-1:0] hs_d, hs_q;
  logic [NUM_LS-1:0] ls_d, ls_q;

  for (genvar g = 0; g < NUM_HS; g++) begin : g_hs
    assign hs_d[g] = spi_hs_i[g] | (hs_den_i[g] & hs_dir_i[g]) | (fs_i & FS_FORCE[g]);
  end

  for (genvar g = 0; g < NUM_LS; g++) begin : g_ls
    assign ls_d[g] = spi_ls_i[g] | (ls_mask_i[g] & ls_dir_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= '0;
      ls_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_en_o = hs_q;
  assign ls_en_o = ls_q;

  // R9
  fs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_i |=> ((hs_q & FS_FORCE) == FS_FORCE));
  // R6
  hs_direct_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_i && hs_den_i == '0) |=> (hs_q == $past(spi_hs_i)));
  // R7
  ls_direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_dir_i |=> (ls_q == $past(spi_ls_i)));
endmodule

// File: rtl/load_switch_ctrl.sv
module load_switch_ctrl
  import lsw_pkg::*;
#(
  parameter int FRAME_W     = FRAME_W_DEF,
  parameter int NUM_HS      = NUM_HS_DEF,
  parameter int NUM_LS      = NUM_LS_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [NUM_HS-1:0] hs_direct,
  input  logic              ls_direct,
  input  logic              fs_req,
  output logic [NUM_HS-1:0] hs_en,
  output logic [NUM_LS-1:0] ls_en,
  output logic [1:0]        sns01_sel,
  output logic [1:0]        sns23_sel
);
  localparam int DIR_W = NUM_HS + 2;

  logic               rst_ni;
  logic [2:0]         spi_s;
  logic [DIR_W-1:0]   dir_s;
  logic               frm_vld;
  logic [FRAME_W-1:0] frm_data;
  logic [NUM_HS-1:0]  spi_hs, hs_den;
  logic [NUM_LS-1:0]  spi_ls, ls_mask;
  logic               fs_act;

  lsw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni));

  lsw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
    .clk(clk), .rst_n(rst_ni), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(spi_s));

  lsw_sync #(.W(DIR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dir_sync (
    .clk(clk), .rst_n(rst_ni), .d({fs_req, ls_direct, hs_direct}), .q(dir_s));

  lsw_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_ni),
    .sclk_i(spi_s[2]), .cs_n_i(spi_s[1]), .mosi_i(spi_s[0]),
    .frm_vld_o(frm_vld), .frm_data_o(frm_data));

  lsw_cfg_regs #(.FRAME_W(FRAME_W), .NUM_HS(NUM_HS), .NUM_LS(NUM_LS)) u_cfg (
    .clk(clk), .rst_n(rst_ni),
    .frm_vld_i(frm_vld), .frm_data_i(frm_data), .fs_req_i(dir_s[DIR_W-1]),
    .spi_hs_o(spi_hs), .spi_ls_o(spi_ls), .hs_den_o(hs_den), .ls_mask_o(ls_mask),
    .sns01_o(sns01_sel), .sns23_o(sns23_sel), .fs_o(fs_act));

  lsw_out_stage #(.NUM_HS(NUM_HS), .NUM_LS(NUM_LS)) u_out (
    .clk(clk), .rst_n(rst_ni),
    .spi_hs_i(spi_hs), .spi_ls_i(spi_ls), .hs_den_i(hs_den), .ls_mask_i(ls_mask),
    .hs_dir_i(dir_s[NUM_HS-1:0]), .ls_dir_i(dir_s[NUM_HS]), .fs_i(fs_act),
    .hs_en_o(hs_en), .ls_en_o(ls_en));

  // R1
  reset_outputs_off_chk: assert property (@(posedge clk)
    !rst_ni |-> (hs_en == '0 && ls_en == '0 && sns01_sel == 2'b00 && sns23_sel == 2'b00));
endmodule

// File: tb/tb_load_switch_ctrl.sv
`timescale 1ns/1ps
module tb_load_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [3:0] hs_dir = '0;
  logic       ls_dir = 1'b0, fs_req = 1'b0;
  logic [3:0] hs_en;
  logic [7:0] ls_en;
  logic [1:0] s01, s23;

  always #2.5 clk = ~clk;

  load_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .hs_direct(hs_dir), .ls_direct(ls_dir), .fs_req(fs_req),
    .hs_en(hs_en), .ls_en(ls_en), .sns01_sel(s01), .sns23_sel(s23));

  // behavioural reference state
  logic [3:0] m_hs = '0, m_den = '0;
  logic [7:0] m_ls = '0, m_mask = '0;
  logic [1:0] m_s01 = '0, m_s23 = '0;
  logic       m_fs = 1'b0;
  int checks = 0, bad = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    quiet = 1'b0;
    step(10);
    quiet = 1'b1;
    step(3);
  endtask

  task automatic model_frame(input logic [15:0] d, input int nbits);
    if (nbits != 16) return;
    if (d[15:14] == 2'b11) return;              // R10
    if (!fs_req) m_fs = 1'b0;                   // R9
    case (d[15:14])
      2'b00: begin m_hs = d[3:0]; m_ls = d[11:4]; end
      2'b01: begin m_den = d[3:0]; m_mask = d[11:4]; end
      default: begin
        if (d[1:0] != 2'b11) m_s01 = d[1:0];
        if (d[3:2] != 2'b11) m_s23 = d[3:2];
      end
    endcase
  endtask

  task automatic send(input logic [15:0] d, input int nbits);
    quiet = 1'b0;
    cs_n = 1'b0;
    step(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? d[15-i] : 1'b0;
      step(4);
      sclk = 1'b1;
      step(4);
      sclk = 1'b0;
    end
    step(4);
    cs_n = 1'b1;
    model_frame(d, nbits);
    settle();
  endtask

  always @(negedge clk) begin
    if (quiet && !done) begin
      logic [3:0] e_hs;
      logic [7:0] e_ls;
      e_hs = m_hs | (m_den & hs_dir) | (m_fs ? 4'b0101 : 4'b0000);
      e_ls = m_ls | (ls_dir ? m_mask : 8'h00);
      checks++;
      if (hs_en !== e_hs || ls_en !== e_ls || s01 !== m_s01 || s23 !== m_s23) begin
        bad++;
        $display("FAIL %s: actual hs=%h ls=%h s01=%0d s23=%0d expected hs=%h ls=%h s01=%0d s23=%0d",
                 cur_req, hs_en, ls_en, s01, s23, e_hs, e_ls, m_s01, m_s23);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, checked during and after reset
    cur_req = "R1";
    step(2);
    quiet = 1'b1;
    step(4);
    rst_n = 1'b1;
    settle();

    // R2: output frame loads all twelve enables
    cur_req = "R2";
    send(16'h0A5C, 16);
    send(16'h0FF3, 16);
    send(16'h0000, 16);

    // R3: bits 13:12 have no effect
    cur_req = "R3";
    send(16'h3123, 16);
    send(16'h1000, 16);

    // R4: wrong bit counts are discarded, idle clock edges not counted
    cur_req = "R4";
    send(16'h0ABC, 15);
    send(16'h0ABC, 17);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; step(4); sclk = 1'b0; step(4);
    end
    send(16'h0456, 16);

    // R6: direct inputs ignored while disabled
    cur_req = "R6";
    send(16'h0000, 16);
    hs_dir = 4'b1111; settle();
    // R5: direct-control frame
    cur_req = "R5";
    send(16'h4005, 16);
    cur_req = "R6";
    hs_dir = 4'b0100; settle();
    hs_dir = 4'b0000; settle();
    send(16'h0002, 16);
    hs_dir = 4'b0011; settle();
    hs_dir = 4'b0000; settle();

    // R7: low-side direct input follows the mask
    cur_req = "R7";
    ls_dir = 1'b1; settle();
    cur_req = "R5";
    send(16'h4F30, 16);
    cur_req = "R7";
    ls_dir = 1'b0; settle();
    ls_dir = 1'b1; settle();
    send(16'h0050, 16);
    ls_dir = 1'b0; settle();

    // R8: sense selection and keep code
    cur_req = "R8";
    send(16'h8006, 16);
    send(16'h800B, 16);
    send(16'h8001, 16);
    send(16'h800F, 16);

    // R10: reserved frame has no effect
    cur_req = "R10";
    send(16'hCFFF, 16);

    // R9: failsafe forcing, holding and clearing
    cur_req = "R9";
    send(16'h0000, 16);
    fs_req = 1'b1; m_fs = 1'b1; settle();
    send(16'h0080, 16);
    fs_req = 1'b0; settle();
    cur_req = "R10";
    send(16'hC000, 16);
    cur_req = "R9";
    send(16'h0002, 16);
    fs_req = 1'b1; m_fs = 1'b1; settle();
    fs_req = 1'b0; settle();
    send(16'h8000, 16);

    // R1: reset mid-run clears everything
    cur_req = "R1";
    send(16'h4FFF, 16);
    send(16'h0FFF, 16);
    quiet = 1'b0;
    rst_n = 1'b0;
    m_hs = '0; m_ls = '0; m_den = '0; m_mask = '0; m_s01 = '0; m_s23 = '0; m_fs = 1'b0;
    step(1);
    quiet = 1'b1;
    step(4);
    rst_n = 1'b1;
    settle();
    ls_dir = 1'b1; hs_dir = 4'b1111; settle();
    ls_dir = 1'b0; hs_dir = 4'b0000; settle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule